// File: doc/BRIEF.md
# Cache Control Register with Flush Sequencer

This block holds the 32-bit control word for a processor with split instruction and data caches. Software reaches it in the system-control address space at offset 0. The word carries a 2-bit operating state for each cache and an instruction burst-fetch enable. It also carries two trigger bits that flush a cache.

A flush trigger does not clear a cache in one step. It starts a sequencer that walks every line of the chosen cache, one line per clock. On each of those clocks the sequencer raises an invalidate strobe together with the line index. A pending flag is visible in the register while the walk runs, so software can poll it until the flush is over. The cache arrays sit outside this block. They take the enable, freeze, strobe and index outputs.

Top module: `cache_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x00000000, both caches are disabled and not frozen, burst fetch is off, and no invalidate strobe is active.
- R2: Bits 1:0 set the instruction cache state: 11 = enabled (ic_en_o=1, ic_frz_o=0), 01 = frozen (ic_en_o=0, ic_frz_o=1), 00 or 10 = disabled (both 0). The written value reads back.
- R3: Bits 3:2 set the data cache state with the same encoding as R2, and drive dc_en_o and dc_frz_o.
- R4: Bit 16 is the instruction burst-fetch enable. It drives burst_o and reads back.
- R5: Writing 1 to bit 21 starts an instruction cache flush. From the next clock, ic_inv_o is high for exactly NUM_LINES consecutive cycles while ic_inv_idx_o counts 0 to NUM_LINES-1. Pending bit 14 reads 1 during those cycles and 0 after them.
- R6: Writing 1 to bit 22 starts a data cache flush with the same timing as R5, on dc_inv_o and dc_inv_idx_o. Its pending flag is bit 15.
- R7: Trigger bits 21 and 22 always read 0. Writes to pending bits 14 and 15 have no effect and start no flush.
- R8: Setting bits 21 and 22 in one write runs both flushes in parallel. Each pending flag clears when its own walk ends.
- R9: A flush trigger for a cache whose flush is still running is ignored. The running walk neither restarts nor lengthens.
- R10: Writes to any offset other than 0 are ignored, and reads at any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for one cycle |
| addr_i | input | ADDR_W | Offset in the system-control space |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ic_en_o | output | 1 | Instruction cache enabled |
| ic_frz_o | output | 1 | Instruction cache frozen |
| dc_en_o | output | 1 | Data cache enabled |
| dc_frz_o | output | 1 | Data cache frozen |
| burst_o | output | 1 | Instruction burst fetch enable |
| ic_inv_o | output | 1 | Instruction cache line invalidate strobe |
| ic_inv_idx_o | output | $clog2(NUM_LINES) | Instruction cache line being invalidated |
| dc_inv_o | output | 1 | Data cache line invalidate strobe |
| dc_inv_idx_o | output | $clog2(NUM_LINES) | Data cache line being invalidated |

## Verification
The flush walk is tried under four trigger patterns:
- **Single flush of either cache.** This separates a correct line count from walks that are one line short or one line long.
- **Both caches triggered in one write.** This exposes any shared counter or cross-coupled completion.
- **Re-trigger in the middle of a walk.** This catches a design that restarts or stretches the walk, because every unexpected strobe meets an empty scoreboard.
- **Writes to the pending bits and to a foreign offset.** These must leave state, strobes and the read-back unchanged.

Each state code, including the second disabled code 10, is checked on the enable and freeze outputs.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int ICS_LO = 0;
  localparam int DCS_LO = 2;
  localparam int IP_BIT = 14;
  localparam int DP_BIT = 15;
  localparam int IB_BIT = 16;
  localparam int FI_BIT = 21;
  localparam int FD_BIT = 22;
  localparam int NCACHE = 2;

  typedef enum logic [1:0] {
    CS_OFF  = 2'b00,
    CS_FRZ  = 2'b01,
    CS_OFFB = 2'b10,
    CS_ON   = 2'b11
  } cstate_e;

  typedef struct packed {
    logic en;
    logic frz;
  } cmode_t;
endpackage

// File: rtl/ccr_state_decode.sv
module ccr_state_decode
  import ccr_pkg::*;
(
  input  logic [1:0] st_i,
  output cmode_t     mode_o
);
  always_comb begin
    mode_o = '0;
    unique case (cstate_e'(st_i))
      CS_ON:   mode_o.en  = 1'b1;
      CS_FRZ:  mode_o.frz = 1'b1;
      default: mode_o = '0;
    endcase
  end
endmodule

// File: rtl/ccr_flush_seq.sv
module ccr_flush_seq #(
  parameter int NUM_LINES = 16,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [LW-1:0] idx_o
);
  localparam logic [LW-1:0] LAST = LW'(NUM_LINES - 1);

  logic          busy_q;
  logic [LW-1:0] idx_q;

  // start while busy is dropped on purpose
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + LW'(1);
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/cache_ctrl_reg.sv
module cache_ctrl_reg
  import ccr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_LINES = 16,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ic_en_o,
  output logic              ic_frz_o,
  output logic              dc_en_o,
  output logic              dc_frz_o,
  output logic              burst_o,
  output logic              ic_inv_o,
  output logic [LW-1:0]     ic_inv_idx_o,
  output logic              dc_inv_o,
  output logic [LW-1:0]     dc_inv_idx_o
);
  localparam int ST_W = 2 * NCACHE;

  logic            hit;
  logic            wr;
  logic [ST_W-1:0] st_q;
  logic            ib_q;
  logic [NCACHE-1:0] busy;
  logic [LW-1:0]     idx [NCACHE];
  cmode_t            mode [NCACHE];

  assign hit = (addr_i == '0);
  assign wr  = we_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      ib_q <= 1'b0;
    end else if (wr) begin
      st_q[ICS_LO +: 2] <= wdata_i[ICS_LO +: 2];
      st_q[DCS_LO +: 2] <= wdata_i[DCS_LO +: 2];
      ib_q              <= wdata_i[IB_BIT];
    end
  end

  for (genvar g = 0; g < NCACHE; g++) begin : g_cache
    localparam int FBIT = (g == 0) ? FI_BIT : FD_BIT;
    localparam int SLO  = (g == 0) ? ICS_LO : DCS_LO;

    ccr_state_decode u_dec (
      .st_i   (st_q[SLO +: 2]),
      .mode_o (mode[g])
    );

    ccr_flush_seq #(.NUM_LINES(NUM_LINES)) u_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (wr && wdata_i[FBIT]),
      .busy_o  (busy[g]),
      .idx_o   (idx[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[ICS_LO +: 2] = st_q[ICS_LO +: 2];
      rdata_o[DCS_LO +: 2] = st_q[DCS_LO +: 2];
      rdata_o[IP_BIT]      = busy[0];
      rdata_o[DP_BIT]      = busy[1];
      rdata_o[IB_BIT]      = ib_q;
    end
  end

  assign ic_en_o      = mode[0].en;
  assign ic_frz_o     = mode[0].frz;
  assign dc_en_o      = mode[1].en;
  assign dc_frz_o     = mode[1].frz;
  assign burst_o      = ib_q;
  assign ic_inv_o     = busy[0];
  assign ic_inv_idx_o = idx[0];
  assign dc_inv_o     = busy[1];
  assign dc_inv_idx_o = idx[1];
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
  parameter int ADDR_W    = 8,
  parameter int NUM_LINES = 16,
  localparam int LW = $clog2(NUM_LINES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              ic_en_o,
  input logic              ic_frz_o,
  input logic              dc_en_o,
  input logic              dc_frz_o,
  input logic              burst_o,
  input logic              ic_inv_o,
  input logic [LW-1:0]     ic_inv_idx_o,
  input logic              dc_inv_o,
  input logic [LW-1:0]     dc_inv_idx_o
);
  localparam logic [LW-1:0] LAST = LW'(NUM_LINES - 1);

  assert_state_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ic_en_o && ic_frz_o));
  assert_state_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dc_en_o && dc_frz_o));
  assert_burst_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0) |=> (burst_o == $past(wdata_i[16])));
  assert_ic_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0 && wdata_i[21] && !ic_inv_o) |=> (ic_inv_o && ic_inv_idx_o == '0));
  assert_ic_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ic_inv_o && ic_inv_idx_o != LAST) |=> (ic_inv_o && ic_inv_idx_o == $past(ic_inv_idx_o) + LW'(1)));
  assert_ic_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ic_inv_o && ic_inv_idx_o == LAST) |=> !ic_inv_o);
  assert_dc_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0 && wdata_i[22] && !dc_inv_o) |=> (dc_inv_o && dc_inv_idx_o == '0));
  assert_dc_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_inv_o && dc_inv_idx_o != LAST) |=> (dc_inv_o && dc_inv_idx_o == $past(dc_inv_idx_o) + LW'(1)));
  assert_dc_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_inv_o && dc_inv_idx_o == LAST) |=> !dc_inv_o);
  assert_trig_rd0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[22:21] == 2'b00);
  assert_foreign_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != '0) |-> (rdata_o == '0));
  assert_foreign_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != '0) |=> ($stable(burst_o) && $stable(ic_en_o) && $stable(dc_en_o)));
endmodule

bind cache_ctrl_reg ccr_checker #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .ic_en_o(ic_en_o), .ic_frz_o(ic_frz_o), .dc_en_o(dc_en_o),
  .dc_frz_o(dc_frz_o), .burst_o(burst_o), .ic_inv_o(ic_inv_o),
  .ic_inv_idx_o(ic_inv_idx_o), .dc_inv_o(dc_inv_o), .dc_inv_idx_o(dc_inv_idx_o)
);

// File: tb/cache_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module cache_ctrl_reg_tb_top;
  localparam int ADDR_W = 8;
  localparam int NL     = 16;
  localparam int LW     = $clog2(NL);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic ic_en_o, ic_frz_o, dc_en_o, dc_frz_o, burst_o, ic_inv_o, dc_inv_o;
  logic [LW-1:0] ic_inv_idx_o, dc_inv_idx_o;

  int errors = 0;
  int checks = 0;
  int ic_q[$];
  int dc_q[$];
  bit done = 0;

  always #2 clk_i = ~clk_i;

  cache_ctrl_reg #(.ADDR_W(ADDR_W), .NUM_LINES(NL)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic rd(string tag, logic [ADDR_W-1:0] a, logic [31:0] exp);
    addr_i = a;
    #0.5;
    chk(tag, rdata_o, exp);
    addr_i = '0;
  endtask

  task automatic push_walk(bit dcache);
    for (int i = 0; i < NL; i++) begin
      if (dcache) dc_q.push_back(i); else ic_q.push_back(i);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitor: every strobe cycle consumes one expected index
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (ic_inv_o) begin
        if (ic_q.size() == 0) chk("R5/R9 unexpected ic strobe", {28'd0, 4'(ic_inv_idx_o)}, 32'hFFFF_FFFF);
        else chk("R5 ic index", 32'(ic_inv_idx_o), 32'(ic_q.pop_front()));
      end
      if (dc_inv_o) begin
        if (dc_q.size() == 0) chk("R6/R9 unexpected dc strobe", {28'd0, 4'(dc_inv_idx_o)}, 32'hFFFF_FFFF);
        else chk("R6 dc index", 32'(dc_inv_idx_o), 32'(dc_q.pop_front()));
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    rd("R1 reset read", 0, 32'h0);
    chk("R1 reset outputs", {25'd0, ic_en_o, ic_frz_o, dc_en_o, dc_frz_o, burst_o, ic_inv_o, dc_inv_o}, 32'h0);

    // R2
    wr(0, 32'h1);
    chk("R2 frozen", {30'd0, ic_en_o, ic_frz_o}, 32'h1);
    rd("R2 readback 01", 0, 32'h1);
    wr(0, 32'h3);
    chk("R2 enabled", {30'd0, ic_en_o, ic_frz_o}, 32'h2);
    wr(0, 32'h2);
    chk("R2 disabled code 10", {30'd0, ic_en_o, ic_frz_o}, 32'h0);
    rd("R2 readback 10", 0, 32'h2);

    // R3
    wr(0, 32'hC);
    chk("R3 enabled", {30'd0, dc_en_o, dc_frz_o}, 32'h2);
    wr(0, 32'h4);
    chk("R3 frozen", {30'd0, dc_en_o, dc_frz_o}, 32'h1);
    wr(0, 32'h8);
    chk("R3 disabled code 10", {30'd0, dc_en_o, dc_frz_o}, 32'h0);

    // R4
    wr(0, 32'h0001_0000);
    chk("R4 burst on", {31'd0, burst_o}, 32'h1);
    rd("R4 readback", 0, 32'h0001_0000);
    wr(0, 32'h0);
    chk("R4 burst off", {31'd0, burst_o}, 32'h0);

    // R7: pending bits not writable, no walk started
    wr(0, 32'h0000_C000);
    repeat (2) @(negedge clk_i);
    rd("R7 pending not writable", 0, 32'h0);

    // R10
    wr(8'h04, 32'h0001_000F);
    chk("R10 foreign write", {28'd0, ic_en_o, dc_en_o, burst_o, 1'b0}, 32'h0);
    rd("R10 foreign read", 8'h04, 32'h0);

    // R5
    push_walk(0);
    wr(0, 32'h0020_0003);
    rd("R5 pending set, trigger reads 0 (R7)", 0, 32'h0000_4003);
    repeat (NL - 1) @(negedge clk_i);
    rd("R5 pending last line", 0, 32'h0000_4003);
    @(negedge clk_i);
    rd("R5 pending cleared", 0, 32'h0000_0003);
    chk("R5 all lines walked", 32'(ic_q.size()), 32'd0);

    // R6
    push_walk(1);
    wr(0, 32'h0040_0000);
    rd("R6 pending set", 0, 32'h0000_8000);
    repeat (NL) @(negedge clk_i);
    rd("R6 pending cleared", 0, 32'h0);
    chk("R6 all lines walked", 32'(dc_q.size()), 32'd0);

    // R8
    push_walk(0);
    push_walk(1);
    wr(0, 32'h0060_0000);
    rd("R8 both pending", 0, 32'h0000_C000);
    repeat (NL) @(negedge clk_i);
    rd("R8 both cleared", 0, 32'h0);
    chk("R8 queues drained", 32'(ic_q.size() + dc_q.size()), 32'd0);

    // R9: re-trigger mid-walk is dropped
    push_walk(0);
    wr(0, 32'h0020_0000);
    repeat (3) @(negedge clk_i);
    wr(0, 32'h0020_0000);
    repeat (NL - 5) @(negedge clk_i);
    rd("R9 pending ends on original schedule", 0, 32'h0);
    repeat (4) @(negedge clk_i);
    chk("R9 no extra lines", 32'(ic_q.size()), 32'd0);

    done = 1;
    finish_run();
  end
endmodule